// File: doc/BRIEF.md
# Timed Debug Reset Scheduler

The block lets software pick a set of reset targets and fire a short pulse on each of them when a countdown runs out. The targets are a debug-system reset, a system-wide power-on reset, and one reset per core in each of two core clusters. Software picks the targets in a control word. It loads an 8-bit count and a hold flag into a schedule word. While the hold flag is clear, the count steps down on every prescaler tick. When the count reaches zero, every selected target gets a pulse and the hardware sets the hold flag again, so the schedule fires only once. A write of a zero count with the hold flag clear fires at once.

Both words sit on a plain register port: address, write strobe, write data and a combinational read-data return. There is no data stream and no back-pressure. Every access completes in the cycle it is presented, and the block never stalls the requester. Each cluster is built with one to four cores, chosen by a parameter. The slots for cores that are not built are tied off.

Top module: `dbg_reset_timer`

## Requirements
- R1: After reset the control word is all zero, the count is 0, the hold flag is 1, and every pulse output is low.
- R2: Word address 0 is the control word. Bit 0 selects the debug-system reset, bit 1 the power-on reset, bits 5:2 cores 0..3 of cluster A, and bits 9:6 cores 0..3 of cluster B. A write is stored at the clock edge, and the read data shows the stored word combinationally in the same cycle the address is presented.
- R3: The control bits of cores beyond CORES_A or CORES_B read as zero and ignore writes, and the pulse outputs for those cores never go high.
- R4: Word address 1 is the schedule word. Bits 7:0 read the live count and bit 8 reads the hold flag. A write loads both fields at the clock edge.
- R5: While the hold flag is 1 and no schedule write occurs, the count does not change, whatever tick_en does.
- R6: While the hold flag is 0, the count drops by exactly one at each clock edge where tick_en is high. It stays unchanged at edges where tick_en is low.
- R7: At the tick that takes the count from 1 to 0, every target whose control bit is 1 starts a pulse visible after that edge. The hold flag becomes 1 and the count stays at 0, with no later pulse.
- R8: A schedule write of count 0 with the hold flag 0 fires the selected targets at that same edge. The hold flag then reads 1.
- R9: A schedule write of a nonzero count with the hold flag 0 starts the countdown at the next tick. If the write sets the hold flag to 1, counting begins only after a later write clears it.
- R10: Each pulse stays high for exactly PULSE_W clock cycles.
- R11: A schedule write at the same edge as an expiring tick wins. The written values are loaded, and the expiry pulse is dropped.
- R12: Addresses other than 0 and 1 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address of the access |
| wr_en | input | 1 | Write strobe for the addressed word |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for the addressed word |
| tick_en | input | 1 | Prescaler tick; one count step per high cycle |
| dbg_sys_rst_o | output | 1 | Debug-system reset pulse |
| por_rst_o | output | 1 | System power-on reset pulse |
| core_rst_a_o | output | 4 | Per-core reset pulses, cluster A |
| core_rst_b_o | output | 4 | Per-core reset pulses, cluster B |

## Verification
Read data is due in the same cycle the address is applied. Register updates, count steps and pulse starts are due one rising edge after the write or tick that causes them. A pulse then stays high for PULSE_W cycles. The bench drives inputs just after a falling edge and advances its reference model at the rising edge. It compares every output and the read data at the next falling edge, so each result is checked in the exact cycle it is due. Directed checks then probe the same-edge conflicts (a write against an expiry) and the pulse length.

// File: rtl/rsch_pkg.sv
package rsch_pkg;
  localparam int N_TGT      = 10;
  localparam int TGT_DBG    = 0;
  localparam int TGT_POR    = 1;
  localparam int CORE_SLOTS = 4;
  localparam int A_LSB      = 2;
  localparam int B_LSB      = A_LSB + CORE_SLOTS;
  localparam int CNT_W      = 8;
  localparam int HOLD_BIT   = CNT_W;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_SCHED = 1;

  // Bits of the control word that exist for the given core counts.
  function automatic logic [N_TGT-1:0] impl_mask(input int ca, input int cb);
    logic [N_TGT-1:0] m;
    m = '0;
    m[TGT_DBG] = 1'b1;
    m[TGT_POR] = 1'b1;
    for (int i = 0; i < CORE_SLOTS; i++) begin
      if (i < ca) m[A_LSB + i] = 1'b1;
      if (i < cb) m[B_LSB + i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/rsch_regs.sv
module rsch_regs
  import rsch_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int CORES_A = 4,
  parameter int CORES_B = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_TGT-1:0]  ctrl_o,
  output logic              sched_wr_o,
  output logic [CNT_W-1:0]  cnt_wdata_o,
  output logic              hold_wdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              hold_i
);
  localparam logic [N_TGT-1:0] MASK = impl_mask(CORES_A, CORES_B);

  logic             sel_ctrl;
  logic             sel_sched;
  logic [N_TGT-1:0] ctrl_q;
  logic             unused_wdata_hi;

  assign sel_ctrl  = (addr == ADDR_W'(ADDR_CTRL));
  assign sel_sched = (addr == ADDR_W'(ADDR_SCHED));
  assign unused_wdata_hi = ^wdata[DATA_W-1:N_TGT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en && sel_ctrl) begin
      ctrl_q <= wdata[N_TGT-1:0] & MASK;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl) begin
      rdata[N_TGT-1:0] = ctrl_q;
    end else if (sel_sched) begin
      rdata[CNT_W-1:0] = cnt_i;
      rdata[HOLD_BIT]  = hold_i;
    end
  end

  assign ctrl_o       = ctrl_q;
  assign sched_wr_o   = wr_en && sel_sched;
  assign cnt_wdata_o  = wdata[CNT_W-1:0];
  assign hold_wdata_o = wdata[HOLD_BIT];

  // R3: absent cores never hold a selection
  p_absent_cores_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~MASK) == '0);

  // R12: stray writes leave the control word alone
  p_stray_write_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_ctrl) |=> $stable(ctrl_q));
endmodule

// File: rtl/rsch_timer.sv
module rsch_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             wr_hold,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hold_q,
  output logic             fire_o
);
  logic imm_fire;
  logic expire;

  // A zero count written with the hold flag clear fires on this edge.
  assign imm_fire = wr && (wr_cnt == '0) && !wr_hold;
  // Expiry is seen one step early so the pulse lines up with reaching zero.
  assign expire   = !wr && !hold_q && tick && (cnt_q <= CNT_W'(1));
  assign fire_o   = imm_fire || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (wr) begin
      cnt_q  <= wr_cnt;
      hold_q <= wr_hold || imm_fire;
    end else if (expire) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (!hold_q && tick) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  // R5: a held count is frozen
  p_hold_freezes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !wr) |=> ($stable(cnt_q) && hold_q));

  // R6: one step per tick
  p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && !wr && tick && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R6: no tick, no movement
  p_idle_without_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !tick) |=> ($stable(cnt_q) && $stable(hold_q)));

  // R7: firing re-arms the hold flag at zero
  p_fire_rehold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (hold_q && cnt_q == '0));

  // R11: a schedule write always lands
  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt_q == $past(wr_cnt)));
endmodule

// File: rtl/rsch_pulse.sv
module rsch_pulse #(
  parameter int N  = 10,
  parameter int PW = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [N-1:0] targets,
  output logic [N-1:0] pulse_o
);
  localparam int PCW = $clog2(PW + 1);

  for (genvar g = 0; g < N; g++) begin : g_tgt
    logic [PCW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        left_q <= '0;
      end else if (fire && targets[g]) begin
        left_q <= PCW'(PW);
      end else if (left_q != '0) begin
        left_q <= left_q - PCW'(1);
      end
    end

    assign pulse_o[g] = (left_q != '0);

    // R10: a pulse only starts from a firing of a selected target
    p_rise_from_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_o[g]) |-> $past(fire && targets[g]));

    // R7: a selected target goes high after a firing
    p_fire_drives_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && targets[g]) |=> pulse_o[g]);
  end
endmodule

// File: rtl/dbg_reset_timer.sv
module dbg_reset_timer
  import rsch_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int CORES_A = 4,
  parameter int CORES_B = 4,
  parameter int PULSE_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tick_en,
  output logic              dbg_sys_rst_o,
  output logic              por_rst_o,
  output logic [3:0]        core_rst_a_o,
  output logic [3:0]        core_rst_b_o
);
  logic [N_TGT-1:0] ctrl;
  logic             sched_wr;
  logic [CNT_W-1:0] cnt_wdata;
  logic             hold_wdata;
  logic [CNT_W-1:0] cnt;
  logic             hold;
  logic             fire;
  logic [N_TGT-1:0] pulses;

  rsch_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CORES_A(CORES_A),
    .CORES_B(CORES_B)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .wdata       (wdata),
    .rdata       (rdata),
    .ctrl_o      (ctrl),
    .sched_wr_o  (sched_wr),
    .cnt_wdata_o (cnt_wdata),
    .hold_wdata_o(hold_wdata),
    .cnt_i       (cnt),
    .hold_i      (hold)
  );

  rsch_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_en),
    .wr     (sched_wr),
    .wr_cnt (cnt_wdata),
    .wr_hold(hold_wdata),
    .cnt_q  (cnt),
    .hold_q (hold),
    .fire_o (fire)
  );

  rsch_pulse #(
    .N (N_TGT),
    .PW(PULSE_W)
  ) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .targets(ctrl),
    .pulse_o(pulses)
  );

  assign dbg_sys_rst_o = pulses[TGT_DBG];
  assign por_rst_o     = pulses[TGT_POR];
  assign core_rst_a_o  = pulses[A_LSB +: CORE_SLOTS];
  assign core_rst_b_o  = pulses[B_LSB +: CORE_SLOTS];

  // R1: nothing pulses while in reset or on the first cycle out of it
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (pulses == '0));
endmodule

// File: tb/dbg_reset_timer_test.sv
`timescale 1ns/1ps
module dbg_reset_timer_test;
  localparam int CA = 4;
  localparam int CB = 3;
  localparam int PW = 3;
  localparam int MASK = 3 | (((1 << CA) - 1) << 2) | (((1 << CB) - 1) << 6);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick_en = 1'b0;
  logic        dbg_sys_rst_o;
  logic        por_rst_o;
  logic [3:0]  core_rst_a_o;
  logic [3:0]  core_rst_b_o;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference model state
  int m_ctrl;
  int m_cnt;
  bit m_hold;
  int m_left[10];
  bit m_fire;
  int m_old;

  always #2.5 clk = ~clk;

  dbg_reset_timer #(
    .ADDR_W (4),
    .DATA_W (32),
    .CORES_A(CA),
    .CORES_B(CB),
    .PULSE_W(PW)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .wr_en        (wr_en),
    .wdata        (wdata),
    .rdata        (rdata),
    .tick_en      (tick_en),
    .dbg_sys_rst_o(dbg_sys_rst_o),
    .por_rst_o    (por_rst_o),
    .core_rst_a_o (core_rst_a_o),
    .core_rst_b_o (core_rst_b_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_hold = 1'b1;
      for (int i = 0; i < 10; i++) m_left[i] = 0;
    end else begin
      m_fire = 1'b0;
      if (wr_en && addr == 4'd1) begin
        m_cnt  = int'(wdata[7:0]);
        m_hold = wdata[8];
        if (wdata[7:0] == 8'd0 && !wdata[8]) begin
          m_fire = 1'b1; m_hold = 1'b1;
        end
      end else if (!m_hold && tick_en) begin
        if (m_cnt <= 1) begin
          m_cnt = 0; m_fire = 1'b1; m_hold = 1'b1;
        end else begin
          m_cnt = m_cnt - 1;
        end
      end
      m_old = m_ctrl;
      if (wr_en && addr == 4'd0) m_ctrl = int'(wdata) & MASK;
      for (int i = 0; i < 10; i++) begin
        if (m_fire && m_old[i]) m_left[i] = PW;
        else if (m_left[i] > 0) m_left[i] = m_left[i] - 1;
      end
    end
  end

  function automatic logic [9:0] model_out();
    logic [9:0] v;
    for (int i = 0; i < 10; i++) v[i] = (m_left[i] != 0);
    return v;
  endfunction

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    if (a == 4'd0) return 32'(m_ctrl);
    if (a == 4'd1) return 32'((int'(m_hold) << 8) | m_cnt);
    return 32'd0;
  endfunction

  function automatic logic [9:0] dut_out();
    return {core_rst_b_o, core_rst_a_o, por_rst_o, dbg_sys_rst_o};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(dut_out() == model_out(), {cur_req, " outputs"}, 32'(dut_out()), 32'(model_out()));
    check(rdata == model_rd(addr), {cur_req, " read data"}, rdata, model_rd(addr));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    check(rdata == exp, tag, rdata, exp);
  endtask

  task automatic expect_out(input logic [9:0] exp, input string tag);
    check(dut_out() == exp, tag, 32'(dut_out()), 32'(exp));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    expect_out(10'h000, "R1 outputs in reset");
    expect_rd(4'd0, 32'h000, "R1 control after reset");
    expect_rd(4'd1, 32'h100, "R1 schedule after reset");
    rst_n = 1'b1;
    cyc();
    expect_out(10'h000, "R1 outputs after release");

    cur_req = "R2";
    wr(4'd0, 32'h0000_0003);
    expect_rd(4'd0, 32'h003, "R2 control readback");

    cur_req = "R3";
    wr(4'd0, 32'hFFFF_FFFF);
    expect_rd(4'd0, 32'h1FF, "R3 absent core bits masked");

    cur_req = "R12";
    wr(4'd2, 32'h0000_0123);
    expect_rd(4'd2, 32'h000, "R12 unmapped read");
    expect_rd(4'd0, 32'h1FF, "R12 control untouched");
    expect_rd(4'd1, 32'h100, "R12 schedule untouched");

    cur_req = "R4";
    wr(4'd1, 32'h105);
    expect_rd(4'd1, 32'h105, "R4 schedule readback");

    cur_req = "R5";
    tick_en = 1'b1;
    repeat (6) cyc();
    expect_rd(4'd1, 32'h105, "R5 held count frozen");
    tick_en = 1'b0;

    cur_req = "R9";
    wr(4'd1, 32'h004);
    repeat (3) cyc();
    expect_rd(4'd1, 32'h004, "R6 no tick no step");
    cur_req = "R6";
    tick_en = 1'b1;
    cyc(); expect_rd(4'd1, 32'h003, "R6 step to 3");
    cyc(); expect_rd(4'd1, 32'h002, "R6 step to 2");
    cyc(); expect_rd(4'd1, 32'h001, "R6 step to 1");
    cur_req = "R7";
    cyc();
    expect_out(10'h1FF, "R7 expiry pulses selected targets");
    expect_rd(4'd1, 32'h100, "R7 hold set at zero");
    repeat (8) cyc();
    expect_out(10'h000, "R7 single shot");
    expect_rd(4'd1, 32'h100, "R7 stays at zero");

    cur_req = "R9";
    wr(4'd1, 32'h103);
    repeat (3) cyc();
    expect_rd(4'd1, 32'h103, "R9 hold written waits");
    wr(4'd1, 32'h003);
    expect_rd(4'd1, 32'h003, "R9 load on clearing write");
    cyc();
    expect_rd(4'd1, 32'h002, "R9 first step after write");
    repeat (6) cyc();
    tick_en = 1'b0;

    cur_req = "R8";
    wr(4'd0, 32'h0A5);
    wr(4'd1, 32'h000);
    expect_out(10'h0A5, "R8 immediate fire");
    expect_rd(4'd1, 32'h100, "R8 hold set after fire");
    cur_req = "R10";
    n = 1;
    while (dbg_sys_rst_o && n < 20) begin
      cyc();
      if (dbg_sys_rst_o) n++;
    end
    check(n == PW, "R10 pulse width", 32'(n), 32'(PW));

    cur_req = "R11";
    wr(4'd1, 32'h002);
    tick_en = 1'b1;
    cyc();
    expect_rd(4'd1, 32'h001, "R11 count at one");
    wr(4'd1, 32'h107);
    expect_out(10'h000, "R11 expiry dropped");
    expect_rd(4'd1, 32'h107, "R11 write loaded");
    repeat (4) cyc();
    expect_out(10'h000, "R11 no late pulse");

    cur_req = "R6";
    wr(4'd1, 32'h006);
    for (int i = 0; i < 40; i++) begin
      tick_en = (i % 3 == 0);
      cyc();
    end
    tick_en = 1'b0;
    expect_rd(4'd1, 32'h100, "R6 sparse ticks reach zero");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule